// File: doc/BRIEF.md
# Supply Diagnostic Fault Aggregator

This block collects pass/fail indications from the analog monitors that watch a device's internal supply rails, reference pins and ground pins. Each indication is latched into one of two sticky fault-status registers. Software clears a bit by writing 1 to its position. Monitoring happens only while the operating mode is one of two enabled codes. In every other mode the monitor inputs have no effect.

Some faults also act on the rest of the device. An undervoltage on the analog supply drops the digital-supply enable and requests a digital reset. When that reset completes, it leaves behind a reset-cause flag that the reset itself does not clear. An undervoltage on the digital supply also requests a reset, but it records nothing. Any fault on the temperature-sense reference forces the over-temperature and under-temperature flag registers to all ones, because temperature readings can no longer be trusted. The digital reset produced here also clears the block's own status and temperature registers.

Top module: `supply_fault_agg`

## Requirements
- R1: After power-on reset, the following outputs read 0: `stat1_o`, `stat2_o`, `ot_o`, `ut_o`, `dig_rst_o`, `rst_cause_o` and `fault_any_o`. `dvdd_en_o` reads 1.
- R2: Monitoring is enabled only when `mode_i` equals 1 (active) or 2 (sleep). For codes 0 and 3, the monitor inputs set no status bit, start no reset, leave `dvdd_en_o` high and force no temperature flags.
- R3: Monitor bits `mon_i[7:0]` set `stat1_o` bits at the same positions. The positions are: 0 analog-supply overvoltage, 1 analog-supply oscillation, 2 digital-supply overvoltage, 3 communication-supply overvoltage, 4 communication-supply undervoltage, 5 reference-low pin open, 6 digital ground open, 7 communication ground open. A bit is visible one cycle after the input is sampled.
- R4: Monitor bits `mon_i[12:8]` set `stat2_o[4:0]`. The mapping is: 8 reference overvoltage to 0, 9 reference undervoltage to 1, 10 reference oscillation to 2, 11 negative-rail undervoltage to 3, 12 high-reference oscillation to 4.
- R5: Status bits are sticky. A 1 in `clr1_i`/`clr2_i` clears that bit on the next edge. If the fault is still present in the same cycle, the bit stays set, because a set wins over a clear.
- R6: A rising analog-supply undervoltage indication (`mon_i[13]`) drives `dig_rst_o` high for exactly RST_CYCLES cycles, starting the cycle after it is sampled. It also drives `dvdd_en_o` low from that same cycle.
- R7: `dvdd_en_o` returns high one cycle after `mon_i[13]` (as gated by mode) has been sampled low at two consecutive edges.
- R8: A rising digital-supply undervoltage indication (`mon_i[14]`) produces the same reset pulse. It sets no status bit, leaves `dvdd_en_o` high and leaves `rst_cause_o` unchanged.
- R9: `rst_cause_o` rises in the cycle `dig_rst_o` falls, after a pulse started by analog-supply undervoltage. The digital reset does not clear it. It clears only on power-on reset or on `clr_cause_i`.
- R10: While `dig_rst_o` is high, `stat1_o`, `stat2_o`, `ot_o` and `ut_o` are cleared and latch nothing.
- R11: Any of `mon_i[10:8]` forces `ot_o` and `ut_o` to all ones on the next edge. Otherwise `ot_i`/`ut_i` bits latch stickily and clear on a 1 in `ot_clr_i`/`ut_clr_i`.
- R12: Overvoltage and oscillation indications on the same rail may be present together, and both bits latch.
- R13: `fault_any_o` is high exactly when any bit of `stat1_o` or `stat2_o` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| mode_i | input | MODE_W | Operating mode code |
| mon_i | input | 15 | Monitor fail indications, bit map per R3, R4, R6, R8 |
| clr1_i | input | 8 | Write-1-to-clear mask for status register 1 |
| clr2_i | input | 5 | Write-1-to-clear mask for status register 2 |
| clr_cause_i | input | 1 | Clears the reset-cause flag |
| ot_i | input | NTEMP | Over-temperature fail indications |
| ut_i | input | NTEMP | Under-temperature fail indications |
| ot_clr_i | input | NTEMP | Write-1-to-clear mask for over-temperature flags |
| ut_clr_i | input | NTEMP | Write-1-to-clear mask for under-temperature flags |
| stat1_o | output | 8 | Fault-status register 1 |
| stat2_o | output | 5 | Fault-status register 2 |
| ot_o | output | NTEMP | Over-temperature flags |
| ut_o | output | NTEMP | Under-temperature flags |
| dig_rst_o | output | 1 | Digital reset request pulse |
| dvdd_en_o | output | 1 | Digital-supply enable |
| rst_cause_o | output | 1 | Reset caused by analog-supply undervoltage |
| fault_any_o | output | 1 | Any status bit set |

## Verification
A status bit that was stored wrongly shows up at `stat1_o`/`stat2_o` and `fault_any_o` one cycle after the stimulus, and it stays wrong because the bits are sticky. A reset-sequencer counter that is off by one changes the number of cycles `dig_rst_o` is high, and it shifts the cycle in which `rst_cause_o` rises. Both are visible within RST_CYCLES+1 cycles of the trigger. A bad restore history for the enable makes `dvdd_en_o` rise one cycle early or late, so it is caught within two cycles of the undervoltage ending.

// File: rtl/sfa_pkg.sv
package sfa_pkg;
   localparam int unsigned MON_W = 15;
   localparam int unsigned S1_W  = 8;
   localparam int unsigned S2_W  = 5;
   // monitor bit positions; status-register positions follow from these
   localparam int unsigned S1_LSB    = 0;
   localparam int unsigned S2_LSB    = S1_LSB + S1_W;
   localparam int unsigned IDX_TREF_OV  = S2_LSB + 0;
   localparam int unsigned IDX_TREF_OSC = S2_LSB + 2;
   localparam int unsigned IDX_AVDD_UV  = S2_LSB + S2_W;
   localparam int unsigned IDX_DVDD_UV  = IDX_AVDD_UV + 1;
endpackage

// File: rtl/sfa_mode_gate.sv
module sfa_mode_gate #(
   parameter int unsigned MODE_W      = 2,
   parameter int unsigned ACTIVE_CODE = 1,
   parameter int unsigned SLEEP_CODE  = 2
) (
   input  logic [MODE_W-1:0] mode_i,
   output logic              en_o
);
   localparam logic [MODE_W-1:0] ACT = MODE_W'(ACTIVE_CODE);
   localparam logic [MODE_W-1:0] SLP = MODE_W'(SLEEP_CODE);

   always_comb en_o = (mode_i == ACT) || (mode_i == SLP);
endmodule

// File: rtl/sfa_sticky_reg.sv
module sfa_sticky_reg #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         por_n,
   input  logic         sync_clr_i,
   input  logic         force_i,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o
);
   for (genvar b = 0; b < W; b++) begin : g_bit
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)          q_o[b] <= 1'b0;
         else if (sync_clr_i) q_o[b] <= 1'b0;
         else if (force_i)    q_o[b] <= 1'b1;
         else if (set_i[b])   q_o[b] <= 1'b1;
         else if (clr_i[b])   q_o[b] <= 1'b0;
      end
   end
endmodule

// File: rtl/sfa_reset_seq.sv
module sfa_reset_seq #(
   parameter int unsigned RST_CYCLES = 4
) (
   input  logic clk,
   input  logic por_n,
   input  logic av_uv_i,
   input  logic dv_uv_i,
   input  logic clr_cause_i,
   output logic rst_o,
   output logic en_o,
   output logic cause_o
);
   localparam int unsigned CW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
   localparam logic [CW-1:0] LOAD = CW'(RST_CYCLES - 1);

   logic          av_q, dv_q, busy_q, from_av_q;
   logic [CW-1:0] cnt_q;
   logic          av_rise, dv_rise, last_cyc;

   always_comb begin
      av_rise = av_uv_i & ~av_q;
      dv_rise = dv_uv_i & ~dv_q;
   end

   if (RST_CYCLES == 1) begin : g_single
      always_comb last_cyc = busy_q;
   end else begin : g_count
      always_comb last_cyc = busy_q && (cnt_q == '0);
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         av_q      <= 1'b0;
         dv_q      <= 1'b0;
         busy_q    <= 1'b0;
         from_av_q <= 1'b0;
         cnt_q     <= '0;
      end else begin
         av_q <= av_uv_i;
         dv_q <= dv_uv_i;
         if (!busy_q) begin
            if (av_rise || dv_rise) begin
               busy_q    <= 1'b1;
               cnt_q     <= LOAD;
               from_av_q <= av_rise;
            end
         end else if (last_cyc) begin
            busy_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   // enable: drops on undervoltage, returns after two quiet samples
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)        en_o <= 1'b1;
      else if (av_uv_i)  en_o <= 1'b0;
      else if (!av_q)    en_o <= 1'b1;
   end

   // cause flag: only power-on reset or software clear removes it
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                      cause_o <= 1'b0;
      else if (last_cyc && from_av_q)  cause_o <= 1'b1;
      else if (clr_cause_i)            cause_o <= 1'b0;
   end

   always_comb rst_o = busy_q;
endmodule

// File: rtl/supply_fault_agg.sv
module supply_fault_agg #(
   parameter int unsigned MODE_W      = 2,
   parameter int unsigned ACTIVE_CODE = 1,
   parameter int unsigned SLEEP_CODE  = 2,
   parameter int unsigned NTEMP       = 4,
   parameter int unsigned RST_CYCLES  = 4
) (
   input  logic                     clk,
   input  logic                     por_n,
   input  logic [MODE_W-1:0]        mode_i,
   input  logic [sfa_pkg::MON_W-1:0] mon_i,
   input  logic [sfa_pkg::S1_W-1:0] clr1_i,
   input  logic [sfa_pkg::S2_W-1:0] clr2_i,
   input  logic                     clr_cause_i,
   input  logic [NTEMP-1:0]         ot_i,
   input  logic [NTEMP-1:0]         ut_i,
   input  logic [NTEMP-1:0]         ot_clr_i,
   input  logic [NTEMP-1:0]         ut_clr_i,
   output logic [sfa_pkg::S1_W-1:0] stat1_o,
   output logic [sfa_pkg::S2_W-1:0] stat2_o,
   output logic [NTEMP-1:0]         ot_o,
   output logic [NTEMP-1:0]         ut_o,
   output logic                     dig_rst_o,
   output logic                     dvdd_en_o,
   output logic                     rst_cause_o,
   output logic                     fault_any_o
);
   import sfa_pkg::*;

   if (RST_CYCLES < 1) begin : g_bad_rst
      $error("RST_CYCLES must be at least 1");
   end
   if (NTEMP < 1) begin : g_bad_ntemp
      $error("NTEMP must be at least 1");
   end
   if (ACTIVE_CODE == SLEEP_CODE || ACTIVE_CODE >= (1 << MODE_W) ||
       SLEEP_CODE >= (1 << MODE_W)) begin : g_bad_mode
      $error("mode codes must be distinct and fit MODE_W");
   end

   logic            mon_en;
   logic [S1_W-1:0] set1;
   logic [S2_W-1:0] set2;
   logic            tref_bad, av_uv_g, dv_uv_g;

   sfa_mode_gate #(
      .MODE_W(MODE_W), .ACTIVE_CODE(ACTIVE_CODE), .SLEEP_CODE(SLEEP_CODE)
   ) u_gate (
      .mode_i(mode_i), .en_o(mon_en)
   );

   always_comb begin
      set1     = mon_i[S1_LSB +: S1_W] & {S1_W{mon_en}};
      set2     = mon_i[S2_LSB +: S2_W] & {S2_W{mon_en}};
      tref_bad = mon_en & (|mon_i[IDX_TREF_OSC:IDX_TREF_OV]);
      av_uv_g  = mon_en & mon_i[IDX_AVDD_UV];
      dv_uv_g  = mon_en & mon_i[IDX_DVDD_UV];
   end

   sfa_reset_seq #(.RST_CYCLES(RST_CYCLES)) u_seq (
      .clk(clk), .por_n(por_n), .av_uv_i(av_uv_g), .dv_uv_i(dv_uv_g),
      .clr_cause_i(clr_cause_i), .rst_o(dig_rst_o), .en_o(dvdd_en_o),
      .cause_o(rst_cause_o)
   );

   sfa_sticky_reg #(.W(S1_W)) u_stat1 (
      .clk(clk), .por_n(por_n), .sync_clr_i(dig_rst_o), .force_i(1'b0),
      .set_i(set1), .clr_i(clr1_i), .q_o(stat1_o)
   );

   sfa_sticky_reg #(.W(S2_W)) u_stat2 (
      .clk(clk), .por_n(por_n), .sync_clr_i(dig_rst_o), .force_i(1'b0),
      .set_i(set2), .clr_i(clr2_i), .q_o(stat2_o)
   );

   sfa_sticky_reg #(.W(NTEMP)) u_ot (
      .clk(clk), .por_n(por_n), .sync_clr_i(dig_rst_o), .force_i(tref_bad),
      .set_i(ot_i & {NTEMP{mon_en}}), .clr_i(ot_clr_i), .q_o(ot_o)
   );

   sfa_sticky_reg #(.W(NTEMP)) u_ut (
      .clk(clk), .por_n(por_n), .sync_clr_i(dig_rst_o), .force_i(tref_bad),
      .set_i(ut_i & {NTEMP{mon_en}}), .clr_i(ut_clr_i), .q_o(ut_o)
   );

   always_comb fault_any_o = (|stat1_o) | (|stat2_o);
endmodule

// File: rtl/sfa_checker.sv
module sfa_checker #(
   parameter int unsigned MODE_W      = 2,
   parameter int unsigned ACTIVE_CODE = 1,
   parameter int unsigned SLEEP_CODE  = 2,
   parameter int unsigned NTEMP       = 4,
   parameter int unsigned RST_CYCLES  = 4
) (
   input logic              clk,
   input logic              por_n,
   input logic [MODE_W-1:0] mode_i,
   input logic [14:0]       mon_i,
   input logic [7:0]        clr1_i,
   input logic [4:0]        clr2_i,
   input logic              clr_cause_i,
   input logic [7:0]        stat1_o,
   input logic [4:0]        stat2_o,
   input logic [NTEMP-1:0]  ot_o,
   input logic [NTEMP-1:0]  ut_o,
   input logic              dig_rst_o,
   input logic              dvdd_en_o,
   input logic              rst_cause_o
);
   logic        mode_ok;
   logic [31:0] hi_cnt;

   always_comb mode_ok = (mode_i == MODE_W'(ACTIVE_CODE)) ||
                         (mode_i == MODE_W'(SLEEP_CODE));

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)         hi_cnt <= '0;
      else if (dig_rst_o) hi_cnt <= hi_cnt + 1;
      else                hi_cnt <= '0;
   end

   assert_gate_R2: assert property (@(posedge clk) disable iff (!por_n)
      (!mode_ok && !dig_rst_o) |=>
         (((stat1_o & ~$past(stat1_o)) == '0) && ((stat2_o & ~$past(stat2_o)) == '0)
          && !dig_rst_o));

   assert_sticky_R5: assert property (@(posedge clk) disable iff (!por_n)
      !dig_rst_o |=> ((($past(stat1_o) & ~$past(clr1_i)) & ~stat1_o) == '0));

   assert_pulse_len_R6: assert property (@(posedge clk) disable iff (!por_n)
      $fell(dig_rst_o) |-> (hi_cnt == RST_CYCLES));

   assert_en_drop_R6: assert property (@(posedge clk) disable iff (!por_n)
      (mode_ok && mon_i[13]) |=> !dvdd_en_o);

   assert_cause_hold_R9: assert property (@(posedge clk) disable iff (!por_n)
      (rst_cause_o && !clr_cause_i) |=> rst_cause_o);

   assert_rst_clear_R10: assert property (@(posedge clk) disable iff (!por_n)
      dig_rst_o |=> ((stat1_o == '0) && (stat2_o == '0) && (ot_o == '0)));

   assert_force_R11: assert property (@(posedge clk) disable iff (!por_n)
      (mode_ok && (|mon_i[10:8]) && !dig_rst_o) |=> ((&ot_o) && (&ut_o)));
endmodule

bind supply_fault_agg sfa_checker #(
   .MODE_W(MODE_W), .ACTIVE_CODE(ACTIVE_CODE), .SLEEP_CODE(SLEEP_CODE),
   .NTEMP(NTEMP), .RST_CYCLES(RST_CYCLES)
) u_chk (
   .clk(clk), .por_n(por_n), .mode_i(mode_i), .mon_i(mon_i),
   .clr1_i(clr1_i), .clr2_i(clr2_i), .clr_cause_i(clr_cause_i),
   .stat1_o(stat1_o), .stat2_o(stat2_o), .ot_o(ot_o), .ut_o(ut_o),
   .dig_rst_o(dig_rst_o), .dvdd_en_o(dvdd_en_o), .rst_cause_o(rst_cause_o)
);

// File: tb/supply_fault_agg_tb_top.sv
module supply_fault_agg_tb_top;
   localparam int NT = 4;
   localparam int RC = 4;

   logic          clk = 1'b0;
   logic          por_n = 1'b0;
   logic [1:0]    mode_i = 2'd1;
   logic [14:0]   mon_i = '0;
   logic [7:0]    clr1_i = '0;
   logic [4:0]    clr2_i = '0;
   logic          clr_cause_i = 1'b0;
   logic [NT-1:0] ot_i = '0, ut_i = '0, ot_clr_i = '0, ut_clr_i = '0;
   logic [7:0]    stat1_o;
   logic [4:0]    stat2_o;
   logic [NT-1:0] ot_o, ut_o;
   logic          dig_rst_o, dvdd_en_o, rst_cause_o, fault_any_o;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   supply_fault_agg #(.NTEMP(NT), .RST_CYCLES(RC)) dut_i (
      .clk(clk), .por_n(por_n), .mode_i(mode_i), .mon_i(mon_i),
      .clr1_i(clr1_i), .clr2_i(clr2_i), .clr_cause_i(clr_cause_i),
      .ot_i(ot_i), .ut_i(ut_i), .ot_clr_i(ot_clr_i), .ut_clr_i(ut_clr_i),
      .stat1_o(stat1_o), .stat2_o(stat2_o), .ot_o(ot_o), .ut_o(ut_o),
      .dig_rst_o(dig_rst_o), .dvdd_en_o(dvdd_en_o), .rst_cause_o(rst_cause_o),
      .fault_any_o(fault_any_o)
   );

   // fields: mode[42:41] mon[40:26] clr1[25:18] clr2[17:13] exp1[12:5] exp2[4:0]
   localparam logic [42:0] VEC [10] = '{
      {2'd1, 15'h0001, 8'h00, 5'h00, 8'h01, 5'h00},   // R3 set
      {2'd1, 15'h0000, 8'h00, 5'h00, 8'h01, 5'h00},   // R5 sticky
      {2'd0, 15'h00FE, 8'h00, 5'h00, 8'h01, 5'h00},   // R2 mode 0
      {2'd3, 15'h1F00, 8'h00, 5'h00, 8'h01, 5'h00},   // R2 mode 3
      {2'd2, 15'h0012, 8'h00, 5'h00, 8'h13, 5'h00},   // R2 sleep, R3
      {2'd1, 15'h0001, 8'h01, 5'h00, 8'h13, 5'h00},   // R5 set wins
      {2'd1, 15'h0000, 8'h03, 5'h00, 8'h10, 5'h00},   // R5 clear
      {2'd1, 15'h0800, 8'h00, 5'h00, 8'h10, 5'h08},   // R4
      {2'd1, 15'h00E0, 8'h00, 5'h00, 8'hF0, 5'h08},   // R3 opens
      {2'd1, 15'h0000, 8'hFF, 5'h1F, 8'h00, 5'h00}    // R5 clear all
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      clr1_i = '0; clr2_i = '0; clr_cause_i = 1'b0; ot_clr_i = '0; ut_clr_i = '0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      int hi;
      repeat (2) @(negedge clk);
      por_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 stat1", 32'(stat1_o), 0);
      check("R1 stat2", 32'(stat2_o), 0);
      check("R1 rst", 32'(dig_rst_o), 0);
      check("R1 en", 32'(dvdd_en_o), 1);
      check("R1 cause", 32'(rst_cause_o), 0);
      check("R1 any", 32'(fault_any_o), 0);

      for (int i = 0; i < 10; i++) begin
         mode_i = VEC[i][42:41];
         mon_i  = VEC[i][40:26];
         clr1_i = VEC[i][25:18];
         clr2_i = VEC[i][17:13];
         step();
         check("R3/R2/R5 stat1", 32'(stat1_o), 32'(VEC[i][12:5]));
         check("R4/R2/R5 stat2", 32'(stat2_o), 32'(VEC[i][4:0]));
         check("R13 any", 32'(fault_any_o), 32'((VEC[i][12:0] != 0)));
      end
      mon_i = '0; mode_i = 2'd1;
      step();

      // R11 reference fault forces temperature flags
      mon_i = 15'h0500;
      step();
      check("R4 tref stat2", 32'(stat2_o), 32'h05);
      check("R11 ot forced", 32'(ot_o), 32'hF);
      check("R11 ut forced", 32'(ut_o), 32'hF);
      mon_i = '0; ot_clr_i = '1; ut_clr_i = '1; clr2_i = '1;
      @(posedge clk); @(negedge clk);
      clr2_i = '0; ot_clr_i = '0; ut_clr_i = '0;
      check("R11 ot cleared", 32'(ot_o), 0);
      ot_i = 4'b0010;
      step();
      ot_i = '0;
      step();
      check("R11 ot sticky", 32'(ot_o), 32'h2);
      ot_clr_i = 4'b0010;
      step();
      check("R11 ot clr", 32'(ot_o), 0);

      // R2 gating of reference fault
      mode_i = 2'd0; mon_i = 15'h0100;
      step();
      check("R2 no force", 32'(ot_o), 0);
      check("R2 no stat2", 32'(stat2_o), 0);
      mode_i = 2'd1; mon_i = '0;
      step();

      // R12 overvoltage and oscillation together
      mon_i = 15'h0003;
      step();
      check("R12 ov+osc", 32'(stat1_o), 32'h03);
      mon_i = '0; clr1_i = '1;
      step();

      // R6 R7 R9 R10 analog undervoltage sequence
      mon_i = 15'h0004;
      step();
      mon_i = 15'h2000;
      step();
      hi = 0;
      if (dig_rst_o) hi++;
      check("R6 rst start", 32'(dig_rst_o), 1);
      check("R6 en low", 32'(dvdd_en_o), 0);
      check("R6 stat before clear", 32'(stat1_o), 32'h04);
      step();
      if (dig_rst_o) hi++;
      check("R10 stat cleared", 32'(stat1_o), 0);
      mon_i = '0;
      step();
      if (dig_rst_o) hi++;
      check("R7 en still low", 32'(dvdd_en_o), 0);
      step();
      if (dig_rst_o) hi++;
      check("R7 en restored", 32'(dvdd_en_o), 1);
      check("R9 cause not yet", 32'(rst_cause_o), 0);
      step();
      if (dig_rst_o) hi++;
      check("R6 pulse length", 32'(hi), RC);
      check("R9 cause set", 32'(rst_cause_o), 1);

      // R8 digital undervoltage
      mon_i = 15'h4000;
      step();
      mon_i = '0;
      check("R8 rst start", 32'(dig_rst_o), 1);
      check("R8 en high", 32'(dvdd_en_o), 1);
      check("R8 no stat", 32'(stat1_o), 0);
      repeat (RC) step();
      check("R8 rst end", 32'(dig_rst_o), 0);
      check("R9 cause survives", 32'(rst_cause_o), 1);
      clr_cause_i = 1'b1;
      @(posedge clk); @(negedge clk);
      clr_cause_i = 1'b0;
      check("R9 cause clear", 32'(rst_cause_o), 0);

      // R2 gated undervoltage
      mode_i = 2'd0; mon_i = 15'h2000;
      step();
      check("R2 no rst", 32'(dig_rst_o), 0);
      check("R2 en kept", 32'(dvdd_en_o), 1);
      mon_i = '0; mode_i = 2'd1;
      step();

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule